// File: doc/BRIEF.md
# Sequential Restoring Divider

This block divides one unsigned integer by another. It produces one quotient bit per clock cycle. A single shift register of 2W+1 bits carries the partial remainder in its upper part. Its lower W bits start with the dividend, and quotient bits replace the dividend one by one from the right as it shifts left. The only arithmetic is one W-bit subtraction. Each cycle the trial difference is written back only when it is not negative, so a separate restore step is never needed.

A caller puts the operands on `dividend` and `divisor` and pulses `start` while `busy` is low. The block loads on that edge and runs for W cycles. It then raises `done` for one cycle, with the quotient and remainder valid. A zero divisor needs no special path: it takes the same number of cycles as any other operands. It sets `div_zero`, returns a quotient of all ones and returns the dividend as the remainder. The results stay on the outputs until the next operation is accepted.

Top module: `seq_restoring_div`

## Requirements
- R1: During reset and after its release, with no start, `busy`, `done` and `div_zero` are low.
- R2: A `start` sampled high while `busy` is low is accepted, and `busy` is high from the next cycle. A `start` seen while `busy` is high is ignored and does not alter the running operation's result.
- R3: `done` is high for exactly one cycle. The first rising edge after the accepting edge counts as edge 1, and `done` is high after edge W. In that cycle `busy` is low, and `done` and `busy` are never high together.
- R4: For a nonzero divisor, when `done` is high, `quotient` equals floor(dividend / divisor) and `remainder` equals dividend mod divisor.
- R5: For a nonzero divisor, the `remainder` presented with `done` is smaller than the divisor.
- R6: A divisor of zero sets `div_zero` and returns a `quotient` of all ones and a `remainder` equal to the dividend, with the same `done` timing as R3.
- R7: `quotient`, `remainder` and `div_zero` hold their values from `done` until the next accepted start.
- R8: With W=6, dividing 60 by 17 gives a quotient of 3 and a remainder of 9.
- R9: Boundary operands give exact results: a dividend smaller than the divisor gives a quotient of 0 and a remainder equal to the dividend; equal operands give 1 and 0; a divisor of 1 gives the dividend and 0; all-ones divided by all-ones gives 1 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a division, taken only while idle |
| dividend | input | W | Unsigned dividend, sampled on the accepting edge |
| divisor | input | W | Unsigned divisor, sampled on the accepting edge |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse, results are valid |
| quotient | output | W | Quotient, valid from done until the next start |
| remainder | output | W | Remainder, valid from done until the next start |
| div_zero | output | 1 | The divisor of the last operation was zero |

## Verification
The assertions check on every cycle:
- the handshake: an accepted start raises `busy`, `done` is a single pulse that never overlaps `busy`, and `done` comes W edges after the accepting edge;
- that results are held while the block is idle;
- that a nonzero-divisor remainder is below the latched divisor;
- that a zero divisor gives a quotient of all ones.

The bench's scenarios are needed to show that the quotient and remainder are numerically correct. They cover random operands, the boundary pairs of R9, the narrow W=6 case, and a second start issued mid-operation that must leave the result untouched.

// File: rtl/seq_restoring_div.sv
module seq_restoring_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         div_zero
);
  localparam int CW = $clog2(W + 1);

  logic [2*W:0]  acc;
  logic [W-1:0]  dvs;
  logic [CW-1:0] step;
  logic          neg;
  logic [W-1:0]  diff;
  logic [W-1:0]  hi_next;

  // upper part is W+1 bits; difference fits in W bits whenever it is kept
  assign neg     = acc[2*W:W] < {1'b0, dvs};
  assign diff    = acc[2*W-1:W] - dvs;
  assign hi_next = neg ? acc[2*W-1:W] : diff;

  assign quotient  = acc[W-1:0];
  assign remainder = acc[2*W:W+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc      <= '0;
      dvs      <= '0;
      step     <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      div_zero <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        acc  <= {hi_next, acc[W-1:0], ~neg};
        step <= step + 1'b1;
        if (step == CW'(W - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (start) begin
        acc      <= {{W{1'b0}}, dividend, 1'b0};
        dvs      <= divisor;
        div_zero <= (divisor == '0);
        step     <= '0;
        busy     <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/seq_restoring_div_chk.sv
module seq_restoring_div_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder,
  input logic         div_zero,
  input logic [W-1:0] dvs
);
  int unsigned since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since <= 0;
    else if (start && !busy) since <= 1;
    else if (busy) since <= since + 1;
  end

  // R3
  done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(done && busy));

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

  // R3
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> since == W + 1);

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy);

  // R5
  rem_below_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_zero) |-> remainder < dvs);

  // R6
  zero_quot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_zero) |-> quotient == {W{1'b1}});

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(quotient) && $stable(remainder) && $stable(div_zero)));
endmodule

bind seq_restoring_div seq_restoring_div_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .quotient(quotient), .remainder(remainder), .div_zero(div_zero), .dvs(dvs)
);

// File: tb/seq_restoring_div_bench.sv
`timescale 1ns/1ps
module seq_restoring_div_bench;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic busy, done, div_zero;
  logic [W-1:0] q, r;

  logic start6 = 1'b0;
  logic [5:0] a6 = '0, b6 = '0;
  logic busy6, done6, dz6;
  logic [5:0] q6, r6;

  int checks = 0, fails = 0;
  string tag = "R4";

  always #4 clk = ~clk;

  seq_restoring_div #(.W(W)) u_seq_restoring_div (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(a), .divisor(b),
    .busy(busy), .done(done), .quotient(q), .remainder(r), .div_zero(div_zero));

  seq_restoring_div #(.W(6)) u_seq_restoring_div_w6 (
    .clk(clk), .rst_n(rst_n), .start(start6), .dividend(a6), .divisor(b6),
    .busy(busy6), .done(done6), .quotient(q6), .remainder(r6), .div_zero(dz6));

  task automatic check(input bit ok, input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // behavioural reference
  logic mbusy = 1'b0, mdone = 1'b0, have = 1'b0, pz = 1'b0;
  int left = 0;
  logic [W-1:0] pq = '0, pr = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mbusy <= 1'b0; mdone <= 1'b0; have <= 1'b0; left <= 0;
    end else begin
      mdone <= 1'b0;
      if (mbusy) begin
        left <= left - 1;
        if (left == 1) begin
          mbusy <= 1'b0; mdone <= 1'b1; have <= 1'b1;
        end
      end else if (start) begin
        mbusy <= 1'b1;
        left  <= W;
        pz    <= (b == 0);
        pq    <= (b == 0) ? {W{1'b1}} : a / b;
        pr    <= (b == 0) ? a : a % b;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      check(busy == 1'b0 && done == 1'b0 && div_zero == 1'b0, "R1", "reset outputs",
            {busy, done, div_zero}, 0);
    end else begin
      check(busy == mbusy, "R2", "busy", busy, mbusy);
      check(done == mdone, "R3", "done", done, mdone);
      if (have && !mbusy) begin
        check(q == pq, tag, "quotient (R7 hold)", q, pq);
        check(r == pr, tag, "remainder (R7 hold)", r, pr);
        check(div_zero == pz, pz ? "R6" : tag, "div_zero", div_zero, pz);
      end
    end
  end

  task automatic op(input logic [W-1:0] x, input logic [W-1:0] y, input string t);
    @(negedge clk);
    while (busy) @(negedge clk);
    tag = t; a = x; b = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (W + 1) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && div_zero == 1'b0, "R1", "idle after reset",
          {busy, done, div_zero}, 0);

    // R8: narrow instance, 60 / 17
    a6 = 6'd60; b6 = 6'd17; start6 = 1'b1;
    @(negedge clk);
    start6 = 1'b0;
    repeat (8) @(negedge clk);
    check(q6 == 6'd3, "R8", "w6 quotient", q6, 3);
    check(r6 == 6'd9, "R8", "w6 remainder", r6, 9);

    // R9 boundaries
    op(32'd5, 32'd9, "R9");
    op(32'd0, 32'd7, "R9");
    op(32'd12345, 32'd12345, "R9");
    op(32'hDEADBEEF, 32'd1, "R9");
    op(32'hFFFFFFFF, 32'hFFFFFFFF, "R9");
    op(32'hFFFFFFFF, 32'd1, "R9");
    // R6 zero divisor
    op(32'h1234ABCD, 32'd0, "R6");
    op(32'd0, 32'd0, "R6");
    // R4 fixed patterns
    op(32'd100, 32'd7, "R4");
    op(32'h80000000, 32'h00010000, "R4");
    op(32'hFFFFFFFF, 32'h80000000, "R4");

    // R2: a second start mid-operation is ignored
    @(negedge clk);
    while (busy) @(negedge clk);
    tag = "R2"; a = 32'd1000; b = 32'd33; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    a = 32'd7; b = 32'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (W) @(negedge clk);
    check(q == 32'd30 && r == 32'd10 && div_zero == 1'b0, "R2", "ignored start result",
          {q, r}, {32'd30, 32'd10});

    // R4 random operands, including small divisors
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] x, y;
      x = $urandom;
      y = $urandom;
      if (i % 3 == 1) y = y >> ($urandom % 32);
      op(x, y, "R4");
    end

    // R7: idle hold over several cycles
    repeat (10) @(negedge clk);
    summary();
    $finish;
  end
endmodule